// File: doc/BRIEF.md
# Deadtime Gate Signal Generator

This block turns one phase's pair of active-low switch commands into two gate-enable signals that are never high together. It serves one phase of a three-phase bridge, so it is placed three times. A fault supervisor drives one common `enable` input into all three copies.

Each command first passes through a deglitch filter. A new level is accepted only after it has been sampled for `FILT_CYC` consecutive clocks. A small state machine then grants the gate. Before any output turns on, a deadtime of `DEAD_CYC` clocks must pass. A gate turns off in the same cycle that its filtered command is released. A separate monitor measures each high-side on-command. It raises a one-cycle flag when the command was shorter than `MIN_ON_CYC` clocks, because the power stage cannot be relied on to reproduce such a pulse. All delays are counted in clocks, and every instance uses the same path. Every output therefore has the same latency.

States of the handover machine:
- `ST_IDLE`: both gates are off.
- `ST_ARM_HI` and `ST_ARM_LO`: the deadtime is being counted for the side that was requested.
- `ST_HI_ON` and `ST_LO_ON`: the gate is driven.

Transitions:
- IDLE→ARM_x: exactly one side is requested.
- ARM_x→x_ON: the count reaches `DEAD_CYC`.
- ARM_x→IDLE and x_ON→IDLE: the sole request for that side is gone. This covers both a release and the case where both sides are requested at once.
- any→IDLE: `enable` is low.

Top module: `gate_pair_ctrl`

## Requirements
- R1: After reset, `hi_gate`, `lo_gate` and `short_pulse` are all 0.
- R2: Polarity and latency. A command held low (logic 0 means "on") turns its gate on. From the idle state, the output goes high `FILT_CYC+DEAD_CYC+1` clocks after the first clock edge that samples the low level. The high side and the low side take exactly the same number of clocks.
- R3: A command level must be sampled for `FILT_CYC` consecutive clocks before it counts. A level change that lasts `FILT_CYC-1` samples has no effect on either gate or on `short_pulse`.
- R4: The two gates are never high in the same cycle.
- R5: Deadtime applies in both handover directions, high side to low side and low side to high side. After one side is released and the other is requested in the same clock, the incoming gate rises `DEAD_CYC+2` clocks after the outgoing gate fell. In every case, a rising gate edge is preceded by at least `DEAD_CYC` sampled cycles in which both gates were low and `enable` was high.
- R6: A gate falls in the same cycle that its filtered command releases. That is `FILT_CYC` clocks after the command is first sampled high, with no deadtime added.
- R7: While both filtered commands request on, both gates are low. They stay low until one command is released. The remaining side then turns on after the normal deadtime.
- R8: While `enable` is low, both gates are low. The gate signals are gated combinationally by `enable`, with no filtering and no deadtime.
- R9: After `enable` rises while one command is held on, that gate rises `DEAD_CYC+1` clocks later.
- R10: `short_pulse` is high for one cycle when a filtered high-side on-command lasted fewer than `MIN_ON_CYC` clocks. It appears `FILT_CYC+W+1` clocks after the first low sample, where W is the length of the low pulse in clocks. A pulse of `MIN_ON_CYC` clocks or more does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global permission from the fault supervisor; low forces both gates off |
| hi_cmd_n | input | 1 | High-side command, active low |
| lo_cmd_n | input | 1 | Low-side command, active low |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |
| short_pulse | output | 1 | One-cycle flag: the last high-side on-command was too short |

## Verification
Single-sided turn-on from idle is tested on both sides. The checks fall on the cycle just before and the cycle of the expected edge, which shows the latencies match and excludes an off-by-one in the filter or the deadtime counter. Simultaneous swaps in both directions show that deadtime is enforced on each handover. Glitches one sample short, on the active side and on the idle side, separate a correct filter from a pass-through. Overlapping requests, an enable drop and re-enable, and high-side pulses of exactly `FILT_CYC`, `FILT_CYC-1`, `MIN_ON_CYC-1` and `MIN_ON_CYC` clocks probe the safe resolution and both edges of the short-pulse rule.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_HI,
        ST_ARM_LO,
        ST_HI_ON,
        ST_LO_ON
    } hand_st_t;

endpackage

// File: rtl/cmd_deglitch.sv
// Accepts a new input level only after it has been sampled FILT_CYC times in a row.
module cmd_deglitch #(
    parameter int   FILT_CYC = 16,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean   <= RST_VAL;
            run_cnt <= '0;
        end else if (raw != clean) begin
            if (run_cnt == CW'(FILT_CYC - 1)) begin
                clean   <= raw;       // R3: level held FILT_CYC samples
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;            // R3: shorter excursion forgotten
        end
    end

endmodule

// File: rtl/handover_fsm.sv
// Grants one gate at a time, counting deadtime before every turn-on.
module handover_fsm
    import gdrv_pkg::*;
#(
    parameter int DEAD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hreq,
    input  logic lreq,
    output logic hi_gate,
    output logic lo_gate
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    hand_st_t      st, nx;
    logic [DW-1:0] dcnt;
    logic          hx, lx, dead_done;

    // R7: a request counts only while the other side is not also requesting
    assign hx        = hreq && !lreq;
    assign lx        = lreq && !hreq;
    assign dead_done = (dcnt == DW'(DEAD_CYC - 1));

    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:   if (hx) nx = ST_ARM_HI;
                       else if (lx) nx = ST_ARM_LO;
            ST_ARM_HI: if (!hx) nx = ST_IDLE;
                       else if (dead_done) nx = ST_HI_ON;
            ST_ARM_LO: if (!lx) nx = ST_IDLE;
                       else if (dead_done) nx = ST_LO_ON;
            ST_HI_ON:  if (!hx) nx = ST_IDLE;
            ST_LO_ON:  if (!lx) nx = ST_IDLE;
            default:   nx = ST_IDLE;
        endcase
        if (!enable) nx = ST_IDLE;   // R8/R9: restart from idle
    end

    // state register with its deadtime counter (R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            dcnt <= '0;
        end else begin
            st   <= nx;
            dcnt <= (nx == st && (st == ST_ARM_HI || st == ST_ARM_LO)) ? dcnt + 1'b1 : '0;
        end
    end

    // outputs: turn-off follows the filtered request in the same cycle (R6, R8)
    always_comb begin
        hi_gate = 1'b0;
        lo_gate = 1'b0;
        unique case (st)
            ST_HI_ON: hi_gate = enable && hx;
            ST_LO_ON: lo_gate = enable && lx;
            ST_IDLE, ST_ARM_HI, ST_ARM_LO: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/hs_pulse_check.sv
// Flags filtered high-side on-commands shorter than MIN_ON_CYC clocks.
module hs_pulse_check #(
    parameter int MIN_ON_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hreq,
    output logic short_pulse
);
    localparam int PW = $clog2(MIN_ON_CYC + 1);

    logic [PW-1:0] on_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_len      <= '0;
            short_pulse <= 1'b0;
        end else if (hreq) begin
            on_len      <= (on_len == PW'(MIN_ON_CYC)) ? on_len : on_len + 1'b1;
            short_pulse <= 1'b0;
        end else begin
            short_pulse <= (on_len != '0) && (on_len < PW'(MIN_ON_CYC));  // R10
            on_len      <= '0;
        end
    end

endmodule

// File: rtl/gate_pair_ctrl.sv
module gate_pair_ctrl #(
    parameter int FILT_CYC   = 16,
    parameter int DEAD_CYC   = 12,
    parameter int MIN_ON_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hi_cmd_n,
    input  logic lo_cmd_n,
    output logic hi_gate,
    output logic lo_gate,
    output logic short_pulse
);
    logic [1:0] raw_n, filt_n;
    logic       hreq, lreq;

    assign raw_n = {hi_cmd_n, lo_cmd_n};   // bit 1 high side, bit 0 low side

    // identical filter on both commands keeps latency matched (R2)
    for (genvar g = 0; g < 2; g++) begin : g_flt
        cmd_deglitch #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_n[g]),
            .clean (filt_n[g])
        );
    end

    assign hreq = ~filt_n[1];
    assign lreq = ~filt_n[0];

    handover_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .hreq    (hreq),
        .lreq    (lreq),
        .hi_gate (hi_gate),
        .lo_gate (lo_gate)
    );

    hs_pulse_check #(.MIN_ON_CYC(MIN_ON_CYC)) u_pw (
        .clk         (clk),
        .rst_n       (rst_n),
        .hreq        (hreq),
        .short_pulse (short_pulse)
    );

endmodule

// File: rtl/gate_pair_ctrl_chk.sv
module gate_pair_ctrl_chk #(
    parameter int DEAD_CYC = 12
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic hi_gate,
    input logic lo_gate,
    input logic short_pulse
);
    localparam int QW = $clog2(DEAD_CYC + 2) + 1;

    // consecutive sampled cycles with both gates low and enable high
    logic [QW-1:0] quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             quiet <= '0;
        else if (hi_gate || lo_gate || !enable) quiet <= '0;
        else if (int'(quiet) < DEAD_CYC + 1)    quiet <= quiet + 1'b1;
    end

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));

    p_disabled_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!hi_gate && !lo_gate));

    p_dead_before_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> (int'(quiet) >= DEAD_CYC));

    p_dead_before_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> (int'(quiet) >= DEAD_CYC));

    p_flag_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        short_pulse |=> !short_pulse);

endmodule

bind gate_pair_ctrl gate_pair_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .hi_gate     (hi_gate),
    .lo_gate     (lo_gate),
    .short_pulse (short_pulse)
);

// File: tb/sim_gate_pair_ctrl.sv
module sim_gate_pair_ctrl;
    localparam int F = 16;
    localparam int D = 12;
    localparam int M = 50;

    typedef struct {
        int    cyc;
        logic  h;
        logic  l;
        logic  f;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic hi_cmd_n = 1'b1;
    logic lo_cmd_n = 1'b1;
    logic hi_gate, lo_gate, short_pulse;

    int   cyc = 0;
    int   errors = 0;
    int   checks = 0;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    gate_pair_ctrl #(.FILT_CYC(F), .DEAD_CYC(D), .MIN_ON_CYC(M)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
        .hi_gate(hi_gate), .lo_gate(lo_gate), .short_pulse(short_pulse)
    );

    // driver side: queue an expected output triple for a given cycle
    task automatic expect_at(int c, logic h, logic l, logic f, string tag);
        exp_t e;
        int   pos;
        e.cyc = c; e.h = h; e.l = l; e.f = f; e.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].cyc > c) begin pos = i; break; end
        end
        sb.insert(pos, e);
    endtask

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    // monitor: compares a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.cyc < cyc) begin
                    errors++;
                    $display("FAIL %s: check for cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
                end else if ({hi_gate, lo_gate, short_pulse} !== {e.h, e.l, e.f}) begin
                    errors++;
                    $display("FAIL %s: cycle %0d hi/lo/flag actual %b%b%b expected %b%b%b",
                             e.tag, cyc, hi_gate, lo_gate, short_pulse, e.h, e.l, e.f);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        expect_at(cyc + 1, 0, 0, 0, "R1 reset state");
        tick(5);

        // R2: high side turn-on from idle
        n = cyc; hi_cmd_n = 1'b0;
        expect_at(n + F + D,     0, 0, 0, "R2 hi not yet on");
        expect_at(n + F + D + 1, 1, 0, 0, "R2 hi on latency");
        tick(40);

        // R3: release glitch one sample short while hi is on
        n = cyc; hi_cmd_n = 1'b1; tick(F - 1); hi_cmd_n = 1'b0;
        expect_at(n + F + 2, 1, 0, 0, "R3 glitch rejected on active side");
        expect_at(n + F + 5, 1, 0, 0, "R3 glitch rejected on active side");
        tick(30);

        // R6: release, immediate turn-off; long pulse gives no flag (R10)
        n = cyc; hi_cmd_n = 1'b1;
        expect_at(n + F - 1, 1, 0, 0, "R6 hi still on");
        expect_at(n + F,     0, 0, 0, "R6 hi off on filtered release");
        expect_at(n + F + 1, 0, 0, 0, "R10 long pulse not flagged");
        tick(40);

        // R2: low side matched latency
        n = cyc; lo_cmd_n = 1'b0;
        expect_at(n + F + D,     0, 0, 0, "R2 lo not yet on");
        expect_at(n + F + D + 1, 0, 1, 0, "R2 lo on latency matched");
        tick(40);

        // R5: low to high handover
        n = cyc; lo_cmd_n = 1'b1; hi_cmd_n = 1'b0;
        expect_at(n + F - 1,     0, 1, 0, "R5 lo before swap");
        expect_at(n + F,         0, 0, 0, "R5 lo off at swap");
        expect_at(n + F + D + 1, 0, 0, 0, "R5 deadtime lo->hi");
        expect_at(n + F + D + 2, 1, 0, 0, "R5 hi on after deadtime");
        tick(60);

        // R5: high to low handover
        n = cyc; hi_cmd_n = 1'b1; lo_cmd_n = 1'b0;
        expect_at(n + F - 1,     1, 0, 0, "R5 hi before swap");
        expect_at(n + F,         0, 0, 0, "R5 hi off at swap");
        expect_at(n + F + 1,     0, 0, 0, "R5 no flag for 60-cycle pulse");
        expect_at(n + F + D + 1, 0, 0, 0, "R5 deadtime hi->lo");
        expect_at(n + F + D + 2, 0, 1, 0, "R5 lo on after deadtime");
        tick(40);

        // R3: short hi glitch while lo is on
        n = cyc; hi_cmd_n = 1'b0; tick(F - 1); hi_cmd_n = 1'b1;
        expect_at(n + F,         0, 1, 0, "R3 idle-side glitch ignored");
        expect_at(n + F + D + 3, 0, 1, 0, "R3 idle-side glitch ignored");
        tick(40);

        // R7: both requested
        n = cyc; hi_cmd_n = 1'b0;
        expect_at(n + F - 1,     0, 1, 0, "R7 lo before overlap");
        expect_at(n + F,         0, 0, 0, "R7 both off on overlap");
        expect_at(n + F + D + 5, 0, 0, 0, "R7 both held off");
        tick(40);
        n = cyc; lo_cmd_n = 1'b1;
        expect_at(n + F + D,     0, 0, 0, "R7 remaining side waits deadtime");
        expect_at(n + F + D + 1, 1, 0, 0, "R7 remaining side on");
        tick(70);

        // R8: enable drop, R9: re-enable
        n = cyc; enable = 1'b0;
        expect_at(n + 1,  0, 0, 0, "R8 off when disabled");
        expect_at(n + 10, 0, 0, 0, "R8 stays off when disabled");
        tick(20);
        n = cyc; enable = 1'b1;
        expect_at(n + D,     0, 0, 0, "R9 waits deadtime after enable");
        expect_at(n + D + 1, 1, 0, 0, "R9 on after re-enable");
        tick(60);
        hi_cmd_n = 1'b1;
        tick(40);

        // R10: pulse of MIN-1 flagged
        n = cyc; hi_cmd_n = 1'b0; tick(M - 1); hi_cmd_n = 1'b1;
        expect_at(n + M - 1 + F - 1, 1, 0, 0, "R10 hi on during pulse");
        expect_at(n + M - 1 + F + 1, 0, 0, 1, "R10 short pulse flagged");
        expect_at(n + M - 1 + F + 2, 0, 0, 0, "R10 flag lasts one cycle");
        tick(40);

        // R10: pulse of exactly MIN not flagged
        n = cyc; hi_cmd_n = 1'b0; tick(M); hi_cmd_n = 1'b1;
        expect_at(n + M + F + 1, 0, 0, 0, "R10 MIN pulse not flagged");
        tick(40);

        // R3: pulse of exactly F accepted, F-1 rejected
        n = cyc; hi_cmd_n = 1'b0; tick(F); hi_cmd_n = 1'b1;
        expect_at(n + 2 * F + 1, 0, 0, 1, "R3 F-sample pulse accepted");
        tick(40);
        n = cyc; hi_cmd_n = 1'b0; tick(F - 1); hi_cmd_n = 1'b1;
        expect_at(n + 2 * F,     0, 0, 0, "R3 F-1 pulse rejected");
        expect_at(n + 2 * F + 1, 0, 0, 0, "R3 F-1 pulse rejected");
        tick(40);

        while (sb.size() > 0) tick(1);
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule